// File: doc/BRIEF.md
# Serial-Port FIFO Pair with Threshold Service Requests

This block holds the sample buffers between a serial audio port and the rest of the chip. It has a transmit FIFO filled through a data port and drained by the serial shifter, and a receive FIFO filled by the serial shifter and drained through the same data port. The two FIFOs keep their own pointers, levels and flags. Both a processor and a DMA engine can service them. Push and pop use a single data location, so a DMA engine can run its bursts at one fixed address.

Each FIFO compares its level with a 4-bit threshold and produces two service requests: an interrupt and a DMA request. Each request has its own enable. The receive side asks for draining once its level rises above the threshold. The transmit side asks for refilling while its level is no more than the threshold plus one. The block reports both levels, full and empty flags, and two sticky error flags: receive overrun and transmit underrun. Samples narrower than the word are right-justified. The block clears the bits above the configured sample size as it stores a write.

Top module: `sfp_pair`

## Requirements
- R1: The transmit and receive FIFOs are independent: traffic on one never changes the level, flags or contents of the other.
- R2: Each FIFO returns entries in the order they were pushed. Its level counts entries from 0 to 16. The full flag is 1 at level 16 and the empty flag is 1 at level 0. After reset both levels are 0 and both FIFOs read as empty.
- R3: rx_irq equals cfg_rx_irq_en AND (rx_level > cfg_rx_thr). rx_dma_req equals cfg_rx_dma_en AND the same condition.
- R4: tx_irq equals cfg_tx_irq_en AND (tx_level <= cfg_tx_thr + 1). tx_dma_req equals cfg_tx_dma_en AND the same condition.
- R5: Each DMA request depends only on its DMA enable, and each interrupt depends only on its interrupt enable. Clearing one enable never masks the other request.
- R6: When dp_rd is high at a clock edge and the receive FIFO holds data, dp_rdata shows the oldest entry after that edge and the level drops by one. dp_rdata holds its value between reads.
- R7: When dp_rd is high at an edge and the receive FIFO is empty, dp_rdata keeps the last value read and the level stays 0.
- R8: A serial push into a full receive FIFO sets rx_ovr. The sample is discarded, the level stays 16 and the stored entries are unchanged.
- R9: A serial pop from an empty transmit FIFO sets tx_udr, drives ser_tx_data to zero after that edge, and leaves the level at 0.
- R10: rx_ovr and tx_udr stay set until a one-cycle pulse on rx_ovr_clr or tx_udr_clr. A new error event in the same cycle as the clear pulse wins, and the flag stays set.
- R11: cfg_dsize holds the sample width minus one, and values below 3 count as 3. A data-port write stores dp_wdata with every bit above cfg_dsize forced to zero.
- R12: A push and a pop on the same FIFO in one cycle leave the level unchanged when the FIFO is not empty. On a full receive FIFO this does not count as an overrun. On an empty FIFO the pop misses and the push is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dp_wr | input | 1 | Data-port write strobe (push to transmit FIFO) |
| dp_wdata | input | 32 | Data-port write value, right-justified sample |
| dp_rd | input | 1 | Data-port read strobe (pop from receive FIFO) |
| dp_rdata | output | 32 | Last value read from the receive FIFO |
| cfg_dsize | input | 5 | Sample width minus one |
| cfg_rx_thr | input | 4 | Receive threshold |
| cfg_tx_thr | input | 4 | Transmit threshold |
| cfg_rx_irq_en | input | 1 | Receive interrupt enable |
| cfg_tx_irq_en | input | 1 | Transmit interrupt enable |
| cfg_rx_dma_en | input | 1 | Receive DMA request enable |
| cfg_tx_dma_en | input | 1 | Transmit DMA request enable |
| ser_rx_push | input | 1 | Serial side pushes a received sample |
| ser_rx_data | input | 32 | Received sample |
| ser_tx_pop | input | 1 | Serial side takes a transmit sample |
| ser_tx_data | output | 32 | Last sample popped for transmission (zero after an underrun) |
| rx_level | output | 5 | Receive FIFO entry count |
| tx_level | output | 5 | Transmit FIFO entry count |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_ovr | output | 1 | Sticky receive overrun |
| tx_udr | output | 1 | Sticky transmit underrun |
| rx_ovr_clr | input | 1 | Clear pulse for rx_ovr |
| tx_udr_clr | input | 1 | Clear pulse for tx_udr |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |

## Verification
Three pairs of events can land on the same edge. A processor or DMA push can meet a serial pop on the transmit FIFO. A serial push can meet a data-port read on a full receive FIFO. An error event can meet the clear pulse of its own sticky flag. The bench provokes each pair by raising both strobes in one cycle, first on a non-empty FIFO and then at the full or empty boundary. It judges the result by the level after the edge, by the value returned on each side, and by whether the error flag is set, checked against R12 and R10.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

  // behaviour of the output register when a pop finds the FIFO empty
  typedef enum logic {
    MISS_HOLD = 1'b0,
    MISS_ZERO = 1'b1
  } miss_e;

  // which abnormal event a FIFO reports on its fault output
  typedef enum logic {
    FLT_PUSH_DROP = 1'b0,
    FLT_POP_MISS  = 1'b1
  } fault_e;

  // direction of the threshold comparison
  typedef enum logic {
    REQ_FILLED  = 1'b0,  // level above threshold
    REQ_DRAINED = 1'b1   // level at or below threshold plus one
  } req_e;

endpackage

// File: rtl/sfp_fifo.sv
module sfp_fifo
  import sfp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter miss_e       MISS  = MISS_HOLD,
  parameter fault_e      FAULT = FLT_PUSH_DROP,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          fault
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] level_q, level_d;
  logic [DW-1:0] data_q, data_d;
  logic [DW-1:0] miss_val;
  logic          push_ok, pop_ok;

  assign full  = (level_q == FULL_LVL);
  assign empty = (level_q == '0);

  // a pop succeeds on any non-empty FIFO; a push also succeeds on a full
  // FIFO when a pop frees a slot on the same edge
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);

  generate
    if (MISS == MISS_ZERO) begin : g_miss_zero
      assign miss_val = '0;
    end else begin : g_miss_hold
      assign miss_val = data_q;
    end
    if (FAULT == FLT_POP_MISS) begin : g_fault_miss
      assign fault = pop && empty;
    end else begin : g_fault_drop
      assign fault = push && !push_ok;
    end
  endgenerate

  always_comb begin
    wr_d    = wr_q;
    rd_d    = rd_q;
    level_d = level_q;
    data_d  = data_q;
    if (push_ok) begin
      wr_d = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_d   = (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
      data_d = mem_q[rd_q];
    end else if (pop) begin
      data_d = miss_val;
    end
    case ({push_ok, pop_ok})
      2'b10:   level_d = level_q + 1'b1;
      2'b01:   level_d = level_q - 1'b1;
      default: level_d = level_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
      data_q  <= '0;
    end else begin
      wr_q    <= wr_d;
      rd_q    <= rd_d;
      level_q <= level_d;
      data_q  <= data_d;
    end
  end

  // storage carries no reset; written only on an accepted push
  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem_q[wr_q] <= push_data;
    end
  end

  assign pop_data = data_q;
  assign level    = level_q;

  // ---------------- assertions ----------------
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_LVL);

  p_full_empty_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  p_drop_keeps_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(level_q));

  p_pushpop_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(level_q));

  generate
    if (MISS == MISS_HOLD) begin : g_chk_hold
      p_empty_read_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> $stable(pop_data));
    end else begin : g_chk_zero
      p_underrun_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |=> (pop_data == '0));
    end
  endgenerate

endmodule

// File: rtl/sfp_req.sv
module sfp_req
  import sfp_pkg::*;
#(
  parameter int unsigned LW   = 5,
  parameter int unsigned TW   = 4,
  parameter req_e        MODE = REQ_FILLED
) (
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] thr,
  input  logic          irq_en,
  input  logic          dma_en,
  output logic          irq,
  output logic          dma
);

  localparam int unsigned XW = ((LW > TW) ? LW : TW) + 1;

  logic [XW-1:0] lvl_x, thr_x;
  logic          hit;

  assign lvl_x = XW'(level);
  assign thr_x = XW'(thr);

  generate
    if (MODE == REQ_DRAINED) begin : g_drained
      assign hit = (lvl_x <= thr_x + XW'(1));
    end else begin : g_filled
      assign hit = (lvl_x > thr_x);
    end
  endgenerate

  assign irq = hit && irq_en;
  assign dma = hit && dma_en;

  // ---------------- assertions ----------------
  always_comb begin
    a_dma_indep_r5: assert (!(dma && !dma_en) && !(irq && !irq_en));
  end

endmodule

// File: rtl/sfp_sticky.sv
module sfp_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  logic flag_q, flag_d;

  // a new event outranks a clear in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign q = flag_q;

  // ---------------- assertions ----------------
  p_sticky_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr) |=> flag_q);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag_q);

endmodule

// File: rtl/sfp_pair.sv
module sfp_pair
  import sfp_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 16,
  parameter int unsigned TW    = 4,
  localparam int unsigned LW   = $clog2(DEPTH + 1),
  localparam int unsigned SW   = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dp_wr,
  input  logic [DW-1:0] dp_wdata,
  input  logic          dp_rd,
  output logic [DW-1:0] dp_rdata,
  input  logic [SW-1:0] cfg_dsize,
  input  logic [TW-1:0] cfg_rx_thr,
  input  logic [TW-1:0] cfg_tx_thr,
  input  logic          cfg_rx_irq_en,
  input  logic          cfg_tx_irq_en,
  input  logic          cfg_rx_dma_en,
  input  logic          cfg_tx_dma_en,
  input  logic          ser_rx_push,
  input  logic [DW-1:0] ser_rx_data,
  input  logic          ser_tx_pop,
  output logic [DW-1:0] ser_tx_data,
  output logic [LW-1:0] rx_level,
  output logic [LW-1:0] tx_level,
  output logic          rx_full,
  output logic          rx_empty,
  output logic          tx_full,
  output logic          tx_empty,
  output logic          rx_ovr,
  output logic          tx_udr,
  input  logic          rx_ovr_clr,
  input  logic          tx_udr_clr,
  output logic          rx_irq,
  output logic          tx_irq,
  output logic          rx_dma_req,
  output logic          tx_dma_req
);

  localparam logic [SW-1:0] MIN_DSIZE = SW'(3);

  logic [SW-1:0] dsize_eff;
  logic [DW-1:0] size_mask;
  logic [DW-1:0] tx_wdata;
  logic          rx_drop, tx_miss;

  // right-justified sample: clear every bit above the configured size
  assign dsize_eff = (cfg_dsize < MIN_DSIZE) ? MIN_DSIZE : cfg_dsize;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      size_mask[i] = (i <= int'(dsize_eff));
    end
  end

  assign tx_wdata = dp_wdata & size_mask;

  // transmit path: data port in, serial side out
  sfp_fifo #(
    .DW(DW), .DEPTH(DEPTH), .MISS(MISS_ZERO), .FAULT(FLT_POP_MISS)
  ) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(dp_wr), .push_data(tx_wdata),
    .pop(ser_tx_pop), .pop_data(ser_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .fault(tx_miss)
  );

  // receive path: serial side in, data port out
  sfp_fifo #(
    .DW(DW), .DEPTH(DEPTH), .MISS(MISS_HOLD), .FAULT(FLT_PUSH_DROP)
  ) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(ser_rx_push), .push_data(ser_rx_data),
    .pop(dp_rd), .pop_data(dp_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .fault(rx_drop)
  );

  sfp_req #(.LW(LW), .TW(TW), .MODE(REQ_FILLED)) u_rx_req (
    .level(rx_level), .thr(cfg_rx_thr),
    .irq_en(cfg_rx_irq_en), .dma_en(cfg_rx_dma_en),
    .irq(rx_irq), .dma(rx_dma_req)
  );

  sfp_req #(.LW(LW), .TW(TW), .MODE(REQ_DRAINED)) u_tx_req (
    .level(tx_level), .thr(cfg_tx_thr),
    .irq_en(cfg_tx_irq_en), .dma_en(cfg_tx_dma_en),
    .irq(tx_irq), .dma(tx_dma_req)
  );

  sfp_sticky u_rx_ovr (
    .clk(clk), .rst_n(rst_n), .set(rx_drop), .clr(rx_ovr_clr), .q(rx_ovr)
  );

  sfp_sticky u_tx_udr (
    .clk(clk), .rst_n(rst_n), .set(tx_miss), .clr(tx_udr_clr), .q(tx_udr)
  );

  // ---------------- assertions ----------------
  p_rx_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_rx_push && !dp_rd) |=> $stable(rx_level));

  p_tx_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dp_wr && !ser_tx_pop) |=> $stable(tx_level));

  p_ovr_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_ovr && !rx_full) |=> !rx_ovr);

endmodule

// File: tb/sfp_pair_bench.sv
module sfp_pair_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dp_wr = 1'b0, dp_rd = 1'b0;
  logic [31:0] dp_wdata = '0, dp_rdata;
  logic [4:0]  cfg_dsize = 5'd31;
  logic [3:0]  cfg_rx_thr = '0, cfg_tx_thr = '0;
  logic        cfg_rx_irq_en = 1'b0, cfg_tx_irq_en = 1'b0;
  logic        cfg_rx_dma_en = 1'b0, cfg_tx_dma_en = 1'b0;
  logic        ser_rx_push = 1'b0, ser_tx_pop = 1'b0;
  logic [31:0] ser_rx_data = '0, ser_tx_data;
  logic [4:0]  rx_level, tx_level;
  logic        rx_full, rx_empty, tx_full, tx_empty;
  logic        rx_ovr, tx_udr;
  logic        rx_ovr_clr = 1'b0, tx_udr_clr = 1'b0;
  logic        rx_irq, tx_irq, rx_dma_req, tx_dma_req;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  sfp_pair u_sfp_pair (
    .clk(clk), .rst_n(rst_n),
    .dp_wr(dp_wr), .dp_wdata(dp_wdata), .dp_rd(dp_rd), .dp_rdata(dp_rdata),
    .cfg_dsize(cfg_dsize), .cfg_rx_thr(cfg_rx_thr), .cfg_tx_thr(cfg_tx_thr),
    .cfg_rx_irq_en(cfg_rx_irq_en), .cfg_tx_irq_en(cfg_tx_irq_en),
    .cfg_rx_dma_en(cfg_rx_dma_en), .cfg_tx_dma_en(cfg_tx_dma_en),
    .ser_rx_push(ser_rx_push), .ser_rx_data(ser_rx_data),
    .ser_tx_pop(ser_tx_pop), .ser_tx_data(ser_tx_data),
    .rx_level(rx_level), .tx_level(tx_level),
    .rx_full(rx_full), .rx_empty(rx_empty), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_ovr(rx_ovr), .tx_udr(tx_udr),
    .rx_ovr_clr(rx_ovr_clr), .tx_udr_clr(tx_udr_clr),
    .rx_irq(rx_irq), .tx_irq(tx_irq), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // every helper starts and ends on a falling edge; state is settled on return
  task automatic cpu_wr(input logic [31:0] d);
    @(negedge clk); dp_wr = 1'b1; dp_wdata = d;
    @(negedge clk); dp_wr = 1'b0;
  endtask

  task automatic cpu_rd(output logic [31:0] d);
    @(negedge clk); dp_rd = 1'b1;
    @(negedge clk); dp_rd = 1'b0; d = dp_rdata;
  endtask

  task automatic ser_push(input logic [31:0] d);
    @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = d;
    @(negedge clk); ser_rx_push = 1'b0;
  endtask

  task automatic ser_pop(output logic [31:0] d);
    @(negedge clk); ser_tx_pop = 1'b1;
    @(negedge clk); ser_tx_pop = 1'b0; d = ser_tx_data;
  endtask

  task automatic t_reset;
    chk("R2 reset rx_level", 32'(rx_level), 0);
    chk("R2 reset tx_level", 32'(tx_level), 0);
    chk("R2 reset empties", {30'd0, rx_empty, tx_empty}, 32'd3);
    chk("R2 reset fulls", {30'd0, rx_full, tx_full}, 32'd0);
    chk("R10 reset error flags", {30'd0, rx_ovr, tx_udr}, 32'd0);
    chk("R3 R4 reset requests disabled", {28'd0, rx_irq, tx_irq, rx_dma_req, tx_dma_req}, 32'd0);
  endtask

  task automatic t_tx_mask;
    logic [31:0] d;
    cfg_dsize = 5'd7;
    cpu_wr(32'hABCD_1234);
    cpu_wr(32'h0000_0155);
    chk("R2 tx level after two writes", 32'(tx_level), 2);
    ser_pop(d); chk("R11 8-bit sample masked", d, 32'h34);
    ser_pop(d); chk("R11 second sample masked, R2 order", d, 32'h55);
    cfg_dsize = 5'd31;
    cpu_wr(32'hFFFF_0001);
    ser_pop(d); chk("R11 full word kept", d, 32'hFFFF_0001);
    cfg_dsize = 5'd1;
    cpu_wr(32'h0000_00FF);
    ser_pop(d); chk("R11 size below 4 bits clamps to 4", d, 32'h0F);
    cfg_dsize = 5'd31;
    chk("R2 tx empty after drain", {31'd0, tx_empty}, 1);
  endtask

  task automatic t_tx_thresh;
    logic [31:0] d;
    cfg_tx_thr = 4'd2; cfg_tx_irq_en = 1'b1; cfg_tx_dma_en = 1'b0;
    #1 chk("R4 tx_irq at level 0", {31'd0, tx_irq}, 1);
    cpu_wr(32'h1); cpu_wr(32'h2); cpu_wr(32'h3);
    chk("R4 tx_irq at level thr+1", {31'd0, tx_irq}, 1);
    chk("R5 tx_dma_req off with dma disabled", {31'd0, tx_dma_req}, 0);
    cpu_wr(32'h4);
    chk("R4 tx_irq off at level thr+2", {31'd0, tx_irq}, 0);
    cfg_tx_irq_en = 1'b0; cfg_tx_dma_en = 1'b1;
    ser_pop(d);
    chk("R5 tx_dma_req with irq disabled", {31'd0, tx_dma_req}, 1);
    chk("R4 tx_irq masked by enable", {31'd0, tx_irq}, 0);
    for (int i = 0; i < 3; i++) ser_pop(d);
    chk("R2 tx order last of four", d, 32'h4);
    cfg_tx_dma_en = 1'b0;
  endtask

  task automatic t_rx_thresh;
    logic [31:0] d;
    cfg_rx_thr = 4'd3; cfg_rx_irq_en = 1'b1; cfg_rx_dma_en = 1'b0;
    for (int i = 0; i < 3; i++) ser_push(32'hA0 + 32'(i));
    chk("R3 rx_irq off at level == thr", {31'd0, rx_irq}, 0);
    chk("R1 tx level untouched by rx pushes", 32'(tx_level), 0);
    ser_push(32'hA3);
    chk("R3 rx_irq on at level thr+1", {31'd0, rx_irq}, 1);
    chk("R5 rx_dma_req off with dma disabled", {31'd0, rx_dma_req}, 0);
    cfg_rx_irq_en = 1'b0; cfg_rx_dma_en = 1'b1;
    #1 chk("R5 rx_dma_req with irq disabled", {30'd0, rx_dma_req, rx_irq}, 32'd2);
    cpu_wr(32'h77);
    chk("R1 rx level untouched by tx write", 32'(rx_level), 4);
    for (int i = 0; i < 4; i++) begin
      cpu_rd(d); chk("R6 rx read order", d, 32'hA0 + 32'(i));
    end
    chk("R3 rx request drops after drain", {31'd0, rx_dma_req}, 0);
    cfg_rx_dma_en = 1'b0;
    ser_pop(d); chk("R1 tx entry intact", d, 32'h77);
  endtask

  task automatic t_overrun;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) ser_push(32'h100 + 32'(i));
    chk("R2 rx full at 16", {27'd0, rx_full, rx_level}, 32'h30);
    ser_push(32'hDEAD);
    chk("R8 overrun flag set", {31'd0, rx_ovr}, 1);
    chk("R8 level stays 16", 32'(rx_level), 16);
    for (int i = 0; i < 16; i++) begin
      cpu_rd(d); chk("R8 contents unchanged after drop", d, 32'h100 + 32'(i));
    end
    chk("R10 overrun flag sticky", {31'd0, rx_ovr}, 1);
    cpu_rd(d);
    chk("R7 empty read repeats last value", d, 32'h10F);
    chk("R7 level stays 0", {26'd0, rx_empty, rx_level}, 32'h20);
    @(negedge clk); rx_ovr_clr = 1'b1;
    @(negedge clk); rx_ovr_clr = 1'b0;
    chk("R10 overrun cleared by pulse", {31'd0, rx_ovr}, 0);
  endtask

  task automatic t_underrun;
    logic [31:0] d;
    cpu_wr(32'h5A);
    ser_pop(d); chk("R2 tx data before underrun", d, 32'h5A);
    ser_pop(d);
    chk("R9 underrun drives zero", d, 0);
    chk("R9 underrun flag set", {31'd0, tx_udr}, 1);
    chk("R9 tx level stays 0", 32'(tx_level), 0);
    @(negedge clk); ser_tx_pop = 1'b1; tx_udr_clr = 1'b1;
    @(negedge clk); ser_tx_pop = 1'b0; tx_udr_clr = 1'b0;
    chk("R10 set wins over clear", {31'd0, tx_udr}, 1);
    @(negedge clk); tx_udr_clr = 1'b1;
    @(negedge clk); tx_udr_clr = 1'b0;
    chk("R10 underrun cleared", {31'd0, tx_udr}, 0);
  endtask

  task automatic t_simul;
    logic [31:0] d;
    cpu_wr(32'h11);
    @(negedge clk); dp_wr = 1'b1; dp_wdata = 32'h22; ser_tx_pop = 1'b1;
    @(negedge clk); dp_wr = 1'b0; ser_tx_pop = 1'b0;
    chk("R12 tx push+pop keeps level", 32'(tx_level), 1);
    chk("R12 tx pop returns older entry", ser_tx_data, 32'h11);
    ser_pop(d); chk("R12 tx pushed entry kept", d, 32'h22);
    @(negedge clk); dp_wr = 1'b1; dp_wdata = 32'h33; ser_tx_pop = 1'b1;
    @(negedge clk); dp_wr = 1'b0; ser_tx_pop = 1'b0;
    chk("R12 empty push+pop: pop misses", {31'd0, tx_udr}, 1);
    chk("R12 empty push+pop: push stored", 32'(tx_level), 1);
    ser_pop(d); chk("R12 stored entry intact", d, 32'h33);
    @(negedge clk); tx_udr_clr = 1'b1;
    @(negedge clk); tx_udr_clr = 1'b0;
    for (int i = 0; i < 16; i++) ser_push(32'h200 + 32'(i));
    @(negedge clk); ser_rx_push = 1'b1; ser_rx_data = 32'h999; dp_rd = 1'b1;
    @(negedge clk); ser_rx_push = 1'b0; dp_rd = 1'b0;
    chk("R12 full rx push+read keeps level", 32'(rx_level), 16);
    chk("R12 no overrun on full push+read", {31'd0, rx_ovr}, 0);
    chk("R12 read returns oldest", dp_rdata, 32'h200);
    for (int i = 0; i < 16; i++) cpu_rd(d);
    chk("R12 late push kept at tail", d, 32'h999);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tx_mask();
    t_tx_thresh();
    t_rx_thresh();
    t_overrun();
    t_underrun();
    t_simul();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule